// File: doc/BRIEF.md
# SHA-512 Two-Round Compression Unit

This unit advances a SHA-512 working state by two compression rounds per request. The eight state words are split into two 256-bit operands, each holding four 64-bit lanes. The first operand carries A, B, E and F. The second carries C, D, G and H. A 128-bit operand carries two precomputed message-word-plus-constant sums, one for each round. The unit returns only the updated A, B, E and F.

After two rounds, the new C, D, G and H equal the old A, B, E and F. The caller therefore feeds the previous first operand back as the next second operand. With this recycling, 40 requests cover a full 80-round block. Message expansion, the round-constant table, initial hash values and the final feed-forward addition belong to the caller.

One round is evaluated per clock on a single shared round datapath. A request is accepted with `start_i`, and `done_o` pulses two cycles later.

Top module: `sha2r_two_round`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `abef_o` is all zeros.
- R2: Each round computes T = choose(E,F,G) + Sigma1(E) + WK + H, where choose = (e&f)^(g&~e) and Sigma1 is the XOR of right-rotations by 14, 18 and 41. The new A is T + majority(A,B,C) + Sigma0(A), where majority = (a&b)^(a&c)^(b&c) and Sigma0 is the XOR of right-rotations by 28, 34 and 39. The new E is T + D. The other words shift: B takes A, C takes B, D takes C, F takes E, G takes F, H takes G.
- R3: Input lanes, where lane n is bits [64n+63:64n]:
  - `abef_i` holds A in lane 3, B in lane 2, E in lane 1 and F in lane 0.
  - `cdgh_i` holds C in lane 3, D in lane 2, G in lane 1 and H in lane 0.
- R4: The first round uses `wk_i[63:0]` and the second round uses `wk_i[127:64]`.
- R5: After two rounds, `abef_o` holds A in lane 3, B in lane 2, E in lane 1 and F in lane 0.
- R6: `start_i` is accepted at a rising edge while the unit is idle. `busy_o` is then 1 for exactly one cycle. `done_o` is then 1 for exactly one cycle, the second cycle after the accepting edge, with the result valid on `abef_o`.
- R7: `start_i` and the data inputs are ignored while `busy_o` is 1. The pending result is unchanged, and no extra request is started.
- R8: `abef_o` holds its value from the `done_o` cycle until the next accepted request completes its first round.
- R9: A `start_i` present in the `done_o` cycle is accepted. A continuously asserted `start_i` therefore issues one request every two cycles.
- R10: Forty chained requests, with the caller recycling operands as described, compute the SHA-512 digest of the message "abc" after the feed-forward addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request two rounds |
| abef_i | input | 256 | A, B, E, F operand |
| cdgh_i | input | 256 | C, D, G, H operand |
| wk_i | input | 128 | Two message-plus-constant sums |
| busy_o | output | 1 | Second round in progress |
| done_o | output | 1 | Result valid pulse |
| abef_o | output | 256 | Updated A, B, E, F |

## Verification
Two functions can fall in the same edge:
- The completion of one request and the acceptance of the next.
- A fresh `start_i` arriving while the second round of a pending request is still being evaluated.

The bench provokes both by holding `start_i` high across successive edges and changing the operands in between. It judges that the request seen during `busy_o` leaves the pending result untouched. It also judges that the request seen in the `done_o` cycle produces its own correct result two cycles later. Every result is compared against an independent round model, and the chained "abc" digest closes the loop end to end.

// File: rtl/sha2r_pkg.sv
`timescale 1ns/1ps
package sha2r_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned LANES   = 4;
  localparam int unsigned HALF_W  = WORD_W * LANES;
  localparam int unsigned WK_W    = WORD_W * 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } st_t;

  function automatic word_t rotr(word_t x, int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(word_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic word_t big_s1(word_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic word_t f_ch(word_t e, word_t f, word_t g);
    return (e & f) ^ (g & ~e);
  endfunction

  function automatic word_t f_maj(word_t a, word_t b, word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction
endpackage

// File: rtl/sha2r_round.sv
`timescale 1ns/1ps
module sha2r_round
  import sha2r_pkg::*;
(
  input  st_t   cur_i,
  input  word_t wk_i,
  output st_t   nxt_o
);
  word_t t_sum;

  always_comb begin
    t_sum     = f_ch(cur_i.e, cur_i.f, cur_i.g) + big_s1(cur_i.e) + wk_i + cur_i.h;
    nxt_o.a   = t_sum + f_maj(cur_i.a, cur_i.b, cur_i.c) + big_s0(cur_i.a);
    nxt_o.b   = cur_i.a;
    nxt_o.c   = cur_i.b;
    nxt_o.d   = cur_i.c;
    nxt_o.e   = t_sum + cur_i.d;
    nxt_o.f   = cur_i.e;
    nxt_o.g   = cur_i.f;
    nxt_o.h   = cur_i.g;
  end
endmodule

// File: rtl/sha2r_ctrl.sv
`timescale 1ns/1ps
module sha2r_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, done_q;

  assign accept_o = start_i & ~busy_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= accept_o;
      done_q <= busy_q;
    end
  end

  // R6
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o);
  // R6
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (done_o && !busy_o));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !busy_o);
endmodule

// File: rtl/sha2r_two_round.sv
`timescale 1ns/1ps
module sha2r_two_round
  import sha2r_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HALF_W-1:0] abef_i,
  input  logic [HALF_W-1:0] cdgh_i,
  input  logic [WK_W-1:0]   wk_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [HALF_W-1:0] abef_o
);
  logic  accept;
  st_t   st_q, st_in, rnd_cur, rnd_nxt;
  word_t wk_hi_q, rnd_wk;

  sha2r_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  // lane 3 is the top word of each half
  always_comb begin
    st_in.a = abef_i[3*WORD_W +: WORD_W];
    st_in.b = abef_i[2*WORD_W +: WORD_W];
    st_in.e = abef_i[1*WORD_W +: WORD_W];
    st_in.f = abef_i[0*WORD_W +: WORD_W];
    st_in.c = cdgh_i[3*WORD_W +: WORD_W];
    st_in.d = cdgh_i[2*WORD_W +: WORD_W];
    st_in.g = cdgh_i[1*WORD_W +: WORD_W];
    st_in.h = cdgh_i[0*WORD_W +: WORD_W];
  end

  // one shared round: first round from the ports, second from the register
  assign rnd_cur = busy_o ? st_q    : st_in;
  assign rnd_wk  = busy_o ? wk_hi_q : wk_i[WORD_W-1:0];

  sha2r_round u_round (
    .cur_i (rnd_cur),
    .wk_i  (rnd_wk),
    .nxt_o (rnd_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= '0;
      wk_hi_q <= '0;
    end else if (accept) begin
      st_q    <= rnd_nxt;
      wk_hi_q <= wk_i[WK_W-1:WORD_W];
    end else if (busy_o) begin
      st_q    <= rnd_nxt;
    end
  end

  assign abef_o = {st_q.a, st_q.b, st_q.e, st_q.f};

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !accept) |=> $stable(abef_o));
endmodule

// File: tb/sha2r_two_round_tb_top.sv
`timescale 1ns/1ps
module sha2r_two_round_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] abef_in = '0, cdgh_in = '0;
  logic [127:0] wk_in = '0;
  logic         busy, done;
  logic [255:0] abef_out;
  int           n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sha2r_two_round dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .abef_i(abef_in), .cdgh_i(cdgh_in), .wk_i(wk_in),
    .busy_o(busy), .done_o(done), .abef_o(abef_out)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  // independent two-round model
  function automatic logic [255:0] ref2(input logic [255:0] abef, input logic [255:0] cdgh, input logic [127:0] wk);
    logic [63:0] a, b, c, d, e, f, g, h, t, na, ne, k;
    a = abef[255:192]; b = abef[191:128]; e = abef[127:64]; f = abef[63:0];
    c = cdgh[255:192]; d = cdgh[191:128]; g = cdgh[127:64]; h = cdgh[63:0];
    for (int r = 0; r < 2; r++) begin
      k  = (r == 0) ? wk[63:0] : wk[127:64];
      t  = ((e & f) ^ (g & ~e)) + (rr(e,14) ^ rr(e,18) ^ rr(e,41)) + k + h;
      na = t + ((a & b) ^ (a & c) ^ (b & c)) + (rr(a,28) ^ rr(a,34) ^ rr(a,39));
      ne = d + t;
      h = g; g = f; f = e; e = ne;
      d = c; c = b; b = a; a = na;
    end
    return {a, b, e, f};
  endfunction

  task automatic run_op(input logic [255:0] abef, input logic [255:0] cdgh, input logic [127:0] wk,
                        output logic [255:0] res, output logic dn);
    @(negedge clk); start = 1'b1; abef_in = abef; cdgh_in = cdgh; wk_in = wk;
    @(negedge clk); start = 1'b0;
    @(negedge clk); dn = done; res = abef_out;
  endtask

  task automatic t_reset;
    chk(!busy && !done, "R1 flags", {busy, done}, 0);
    chk(abef_out == '0, "R1 abef_o", abef_out, 0);
  endtask

  task automatic t_vec(input logic [255:0] abef, input logic [255:0] cdgh, input logic [127:0] wk, input string req);
    logic [255:0] res, exp; logic dn;
    exp = ref2(abef, cdgh, wk);
    run_op(abef, cdgh, wk, res, dn);
    chk(dn, {req, " done"}, dn, 1);
    chk(res == exp, req, res, exp);
  endtask

  task automatic t_timing;
    logic [255:0] exp;
    exp = ref2({4{64'h0123_4567_89ab_cdef}}, {4{64'hfedc_ba98_7654_3210}}, {64'h11, 64'h22});
    @(negedge clk); start = 1'b1;
    abef_in = {4{64'h0123_4567_89ab_cdef}}; cdgh_in = {4{64'hfedc_ba98_7654_3210}}; wk_in = {64'h11, 64'h22};
    @(negedge clk); start = 1'b0;
    chk(busy && !done, "R6 first cycle", {busy, done}, 2'b10);
    @(negedge clk);
    chk(!busy && done && abef_out == exp, "R6 second cycle", {busy, done, abef_out}, {2'b01, exp});
    @(negedge clk);
    chk(!busy && !done, "R6 pulse ends", {busy, done}, 0);
  endtask

  task automatic t_ignore;
    logic [255:0] exp;
    exp = ref2({64'h1, 64'h2, 64'h3, 64'h4}, {64'h5, 64'h6, 64'h7, 64'h8}, {64'h9, 64'ha});
    @(negedge clk); start = 1'b1;
    abef_in = {64'h1, 64'h2, 64'h3, 64'h4}; cdgh_in = {64'h5, 64'h6, 64'h7, 64'h8}; wk_in = {64'h9, 64'ha};
    @(negedge clk);
    abef_in = '1; cdgh_in = '1; wk_in = '1;
    @(negedge clk); start = 1'b0;
    chk(done && abef_out == exp, "R7 result kept", abef_out, exp);
    @(negedge clk);
    chk(!busy && !done && abef_out == exp, "R7 no extra op", {busy, done, abef_out}, {2'b00, exp});
  endtask

  task automatic t_hold;
    logic [255:0] res, exp; logic dn;
    exp = ref2({4{64'haaaa_5555_aaaa_5555}}, '0, '1);
    run_op({4{64'haaaa_5555_aaaa_5555}}, '0, '1, res, dn);
    abef_in = '1; cdgh_in = {4{64'h77}}; wk_in = 128'h3;
    repeat (3) @(negedge clk);
    chk(abef_out == exp && !done, "R8 hold", abef_out, exp);
  endtask

  task automatic t_b2b;
    logic [255:0] e1, e2;
    e1 = ref2({64'hdead, 64'hbeef, 64'hcafe, 64'hf00d}, {64'h1111, 64'h2222, 64'h3333, 64'h4444}, {64'h55, 64'h66});
    e2 = ref2({64'h9, 64'h8, 64'h7, 64'h6}, {64'h5, 64'h4, 64'h3, 64'h2}, {64'hffff_ffff_ffff_ffff, 64'h1});
    @(negedge clk); start = 1'b1;
    abef_in = {64'hdead, 64'hbeef, 64'hcafe, 64'hf00d}; cdgh_in = {64'h1111, 64'h2222, 64'h3333, 64'h4444}; wk_in = {64'h55, 64'h66};
    @(negedge clk);
    @(negedge clk);
    chk(done && abef_out == e1, "R9 first", abef_out, e1);
    abef_in = {64'h9, 64'h8, 64'h7, 64'h6}; cdgh_in = {64'h5, 64'h4, 64'h3, 64'h2}; wk_in = {64'hffff_ffff_ffff_ffff, 64'h1};
    @(negedge clk); start = 1'b0;
    chk(busy, "R9 accepted in done cycle", busy, 1);
    @(negedge clk);
    chk(done && abef_out == e2, "R9 second", abef_out, e2);
  endtask

  function automatic bit is_prime(input int n);
    for (int i = 2; i * i <= n; i++) if (n % i == 0) return 0;
    return 1;
  endfunction

  function automatic logic [63:0] cube_frac(input int p);
    logic [71:0] y, cand; logic [215:0] tgt, c3;
    tgt = 216'(p) << 192; y = '0;
    for (int b = 67; b >= 0; b--) begin
      cand = y | (72'(1) << b);
      c3 = 216'(cand) * 216'(cand) * 216'(cand);
      if (c3 <= tgt) y = cand;
    end
    return y[63:0];
  endfunction

  task automatic t_abc;
    logic [63:0] kc [80];
    logic [63:0] w  [80];
    logic [63:0] iv [8];
    logic [63:0] s0, s1;
    logic [255:0] abef, cdgh, res;
    logic [511:0] dig, exp;
    logic dn;
    int pr, missed;
    pr = 2;
    for (int i = 0; i < 80; i++) begin
      while (!is_prime(pr)) pr++;
      kc[i] = cube_frac(pr);
      pr++;
    end
    iv[0] = 64'h6a09e667f3bcc908; iv[1] = 64'hbb67ae8584caa73b;
    iv[2] = 64'h3c6ef372fe94f82b; iv[3] = 64'ha54ff53a5f1d36f1;
    iv[4] = 64'h510e527fade682d1; iv[5] = 64'h9b05688c2b3e6c1f;
    iv[6] = 64'h1f83d9abfb41bd6b; iv[7] = 64'h5be0cd19137e2179;
    for (int i = 0; i < 16; i++) w[i] = '0;
    w[0] = 64'h6162638000000000; w[15] = 64'd24;
    for (int t = 16; t < 80; t++) begin
      s0 = rr(w[t-15],1) ^ rr(w[t-15],8) ^ (w[t-15] >> 7);
      s1 = rr(w[t-2],19) ^ rr(w[t-2],61) ^ (w[t-2] >> 6);
      w[t] = s1 + w[t-7] + s0 + w[t-16];
    end
    abef = {iv[0], iv[1], iv[4], iv[5]};
    cdgh = {iv[2], iv[3], iv[6], iv[7]};
    missed = 0;
    for (int t = 0; t < 80; t += 2) begin
      run_op(abef, cdgh, {w[t+1] + kc[t+1], w[t] + kc[t]}, res, dn);
      if (!dn) missed++;
      cdgh = abef; abef = res;
    end
    dig = {abef[255:192] + iv[0], abef[191:128] + iv[1], cdgh[255:192] + iv[2], cdgh[191:128] + iv[3],
           abef[127:64]  + iv[4], abef[63:0]    + iv[5], cdgh[127:64]  + iv[6], cdgh[63:0]    + iv[7]};
    exp = 512'hddaf35a193617abacc417349ae20413112e6fa4e89a97ea20a9eeee64b55d39a2192992a274fc1a836ba3c23a3feebbd454d4423643ce80e2a9ac94fa54ca49f;
    chk(missed == 0, "R10 done per request", missed, 0);
    chk(dig == exp, "R10 abc digest", dig, exp);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_vec('0, '0, '0, "R2 zeros");
    t_vec('1, '1, '1, "R2 ones");
    t_vec({4{64'h5a5a_a5a5_0f0f_f0f0}}, {4{64'h3c3c_c3c3_9696_6969}}, {64'h0, 64'h8000_0000_0000_0001}, "R2 pattern");
    t_vec({64'h1111_0000_0000_0001, 64'h2222_0000_0000_0002, 64'h3333_0000_0000_0003, 64'h4444_0000_0000_0004},
          {64'h5555_0000_0000_0005, 64'h6666_0000_0000_0006, 64'h7777_0000_0000_0007, 64'h8888_0000_0000_0008},
          {64'h0, 64'h0}, "R3 R5 lanes");
    t_vec({4{64'h0}}, {4{64'h0}}, {64'h0, 64'h1234_5678_9abc_def0}, "R4 wk low lane");
    t_vec({4{64'h0}}, {4{64'h0}}, {64'h1234_5678_9abc_def0, 64'h0}, "R4 wk high lane");
    t_timing();
    t_ignore();
    t_hold();
    t_b2b();
    t_abc();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule